// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between five asynchronous interrupt pins and an interrupt controller. Each channel has a small control register that picks edge or level sensing and a polarity. The block turns pin activity into one-clock set pulses for the matching request bits. Arbitration between channels happens elsewhere; this block only decides when a request bit must be set.

Every pin and every key line passes through a two-flop synchroniser. The detector compares the current synchronised sample with the previous one in edge mode, and looks at the current sample alone in level mode. Channel 3 can take its input from a group of key lines instead of its own pin. The group is either the lower four lines or all five, and the chosen lines are merged into one signal. The polarity bit means opposite things in the two modes. With polarity 0, level mode is active high but edge mode fires on a falling edge. With polarity 1, level mode is active low and edge mode fires on a rising edge.

Channel 4's control register is write-protected from reset. Writes to it take effect only while an unlock bit in a separate function-select register is 1. Control registers and the function-select register share one write port addressed by register index.

Top module: `extint_conditioner`

## Requirements
- R1: After reset, `req_set` is 0 and every control register is cleared: edge mode, polarity 0, channel 3 fed by its own pin, channel 4 locked.
- R2: In edge mode with polarity 0, a channel gives a single one-cycle pulse when its input goes from 1 to 0, and gives no pulse when the input goes from 0 to 1.
- R3: In edge mode with polarity 1, a channel gives a single one-cycle pulse when its input goes from 0 to 1, and gives no pulse when the input goes from 1 to 0.
- R4: In level mode with polarity 0, a channel pulses in every cycle while its synchronised input is 1.
- R5: In level mode with polarity 1, a channel pulses in every cycle while its synchronised input is 0.
- R6: A pin change made between clock edges shows on `req_set` after the third rising edge that follows it. That is two synchroniser stages plus the output register. An edge pulse is gone after the fourth edge.
- R7: Writes use `wr_addr` 0..4 for the channel control registers. Bit 4 is polarity and bit 5 is the mode (0 edge, 1 level). Bits 3..0 have no effect on detection.
- R8: Channel 3 source code 2'b10 (written to bits 7:6 of its register) uses key lines 3..0. The lines are ANDed for polarity 0 and ORed for polarity 1. Key line 4 and the channel 3 pin are then ignored.
- R9: Channel 3 source code 2'b11 uses all five key lines, with the same merge rule as R8.
- R10: Channel 3 source code 2'b01 is reserved and disconnects the source, so channel 3 never pulses while this code is held.
- R11: A write to address 4 is ignored while the unlock bit is 0. The unlock bit is bit 5 of the function-select register at address 5. Writes to address 4 apply while that bit is 1.
- R12: Channels are independent: activity or configuration on one channel never changes another channel's pulses.

Bits 7:6 of the control registers of channels other than 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 5 | Asynchronous external interrupt pins, one per channel |
| key_in | input | 5 | Asynchronous key-group lines, usable as the channel 3 source |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Register index: 0..4 channel control, 5 function-select |
| wr_data | input | 8 | Write data |
| req_set | output | 5 | One-cycle request-bit set pulses, one bit per channel |

## Verification
The assertions check on every cycle that:
- an edge-mode pulse never lasts two cycles while the polarity holds;
- any cycle with an active level leads to a pulse one cycle later;
- a locked write leaves channel 4's mode and polarity unchanged;
- the reserved source code silences channel 3;
- reset clears the outputs.

The scoreboard scenarios are needed for the rest:
- the exact three-edge latency;
- the opposite polarity meanings of the two modes;
- the AND and OR merging of the narrow and wide key groups;
- the low data bits and the key-line 4 and pin inputs having no effect;
- a lock that applies again when the unlock bit is cleared.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

  localparam int CTL_W      = 8;
  localparam int POL_BIT    = 4;
  localparam int LVL_BIT    = 5;
  localparam int KSEL_LSB   = 6;
  localparam int UNLOCK_BIT = 5;

  typedef enum logic [1:0] {
    KSRC_PIN    = 2'b00,
    KSRC_RSVD   = 2'b01,
    KSRC_NARROW = 2'b10,
    KSRC_WIDE   = 2'b11
  } ksrc_e;

  typedef struct packed {
    ksrc_e ksel;
    logic  lvl;
    logic  pol;
  } ext_ctl_t;

  // pol 0: falling edge fires; pol 1: rising edge fires
  function automatic logic edge_hit(logic cur, logic prv, logic pol);
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // pol 0: high level active; pol 1: low level active
  function automatic logic level_hit(logic cur, logic pol);
    return pol ? ~cur : cur;
  endfunction

  function automatic ext_ctl_t decode_ctl(logic [CTL_W-1:0] d, logic keep_ksel);
    ext_ctl_t r;
    r.pol  = d[POL_BIT];
    r.lvl  = d[LVL_BIT];
    r.ksel = keep_ksel ? ksrc_e'(d[KSEL_LSB +: 2]) : KSRC_PIN;
    return r;
  endfunction

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/extint_ctl_regs.sv
`timescale 1ns/1ps
module extint_ctl_regs
  import extint_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int ADDR_W    = 3,
  parameter int KEY_CH    = 3,
  parameter int LOCK_CH   = 4,
  parameter int FSEL_ADDR = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CTL_W-1:0]        wr_data,
  output ext_ctl_t [NUM_CH-1:0]   ctl_o,
  output logic                    unlock_o
);

  logic unlock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      unlock_q <= 1'b0;
    else if (wr_en && (wr_addr == ADDR_W'(FSEL_ADDR)))
      unlock_q <= wr_data[UNLOCK_BIT];
  end

  assign unlock_o = unlock_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ctl
    localparam bit HAS_KSEL = (ch == KEY_CH);
    localparam bit IS_LOCK  = (ch == LOCK_CH);
    ext_ctl_t ctl_q;
    logic     sel_hit;
    logic     allow;

    assign sel_hit = wr_en && (wr_addr == ADDR_W'(ch));
    assign allow   = IS_LOCK ? unlock_q : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctl_q <= '0;
      else if (sel_hit && allow)
        ctl_q <= decode_ctl(wr_data, HAS_KSEL);
    end

    assign ctl_o[ch] = ctl_q;
  end

endmodule

// File: rtl/extint_key_src.sv
`timescale 1ns/1ps
module extint_key_src
  import extint_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic             pin_s,
  input  logic [KEY_W-1:0] keys_s,
  input  ksrc_e            ksel,
  input  logic             pol,
  output logic             sig,
  output logic             src_en
);

  localparam logic [KEY_W-1:0] WIDE_M   = '1;
  localparam logic [KEY_W-1:0] NARROW_M = WIDE_M >> 1;

  // AND for falling/high sensing, OR for rising/low sensing
  function automatic logic merge(logic [KEY_W-1:0] k, logic [KEY_W-1:0] m, logic p);
    return p ? |(k & m) : &(k | ~m);
  endfunction

  always_comb begin
    sig    = 1'b0;
    src_en = 1'b1;
    unique case (ksel)
      KSRC_PIN:    sig = pin_s;
      KSRC_RSVD:   src_en = 1'b0;
      KSRC_NARROW: sig = merge(keys_s, NARROW_M, pol);
      KSRC_WIDE:   sig = merge(keys_s, WIDE_M, pol);
    endcase
  end

endmodule

// File: rtl/extint_detect.sv
`timescale 1ns/1ps
module extint_detect
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic src_en,
  input  logic lvl,
  input  logic pol,
  output logic req_o
);

  logic prev_q;
  logic req_q;
  logic hit;

  assign hit = src_en & (lvl ? level_hit(sig, pol) : edge_hit(sig, prev_q, pol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= sig;
      req_q  <= hit;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/extint_conditioner.sv
`timescale 1ns/1ps
module extint_conditioner
  import extint_pkg::*;
#(
  parameter int NUM_CH      = 5,
  parameter int KEY_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int KEY_CH      = 3,
  parameter int LOCK_CH     = 4,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ext_pin,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTL_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] req_set
);

  localparam int FSEL_ADDR = NUM_CH;
  localparam int SYNC_W    = NUM_CH + KEY_W;

  // named internal events, also observed by the bound checker
  logic [SYNC_W-1:0]     sync_q;
  logic [NUM_CH-1:0]     pin_s;
  logic [KEY_W-1:0]      key_s;
  ext_ctl_t [NUM_CH-1:0] ctl;
  logic                  unlock;
  logic [NUM_CH-1:0]     lvl_mode;
  logic [NUM_CH-1:0]     pol_sel;
  logic [NUM_CH-1:0]     sig_s;
  logic [NUM_CH-1:0]     src_en;
  logic [1:0]            key_ksel;
  logic                  key_sig;
  logic                  key_en;

  extint_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({key_in, ext_pin}),
    .q     (sync_q)
  );

  assign pin_s = sync_q[NUM_CH-1:0];
  assign key_s = sync_q[SYNC_W-1:NUM_CH];

  extint_ctl_regs #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .KEY_CH    (KEY_CH),
    .LOCK_CH   (LOCK_CH),
    .FSEL_ADDR (FSEL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctl_o    (ctl),
    .unlock_o (unlock)
  );

  assign key_ksel = ctl[KEY_CH].ksel;

  extint_key_src #(.KEY_W(KEY_W)) u_key_src (
    .pin_s  (pin_s[KEY_CH]),
    .keys_s (key_s),
    .ksel   (ctl[KEY_CH].ksel),
    .pol    (ctl[KEY_CH].pol),
    .sig    (key_sig),
    .src_en (key_en)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign lvl_mode[ch] = ctl[ch].lvl;
    assign pol_sel[ch]  = ctl[ch].pol;

    if (ch == KEY_CH) begin : g_key
      assign sig_s[ch]  = key_sig;
      assign src_en[ch] = key_en;
    end else begin : g_pin
      assign sig_s[ch]  = pin_s[ch];
      assign src_en[ch] = 1'b1;
    end

    extint_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig    (sig_s[ch]),
      .src_en (src_en[ch]),
      .lvl    (lvl_mode[ch]),
      .pol    (pol_sel[ch]),
      .req_o  (req_set[ch])
    );
  end

endmodule

// File: rtl/extint_checker.sv
`timescale 1ns/1ps
module extint_checker #(
  parameter int NUM_CH  = 5,
  parameter int KEY_CH  = 3,
  parameter int LOCK_CH = 4,
  parameter int ADDR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NUM_CH-1:0] req_set,
  input logic [NUM_CH-1:0] sig_s,
  input logic [NUM_CH-1:0] src_en,
  input logic [NUM_CH-1:0] lvl_mode,
  input logic [NUM_CH-1:0] pol_sel,
  input logic [1:0]        key_ksel,
  input logic              unlock
);

  logic [NUM_CH-1:0] lvl_active;
  logic [1:0]        lock_view;

  // active level per channel, expressed through the mode inputs
  assign lvl_active = src_en & lvl_mode & (sig_s ^ pol_sel);
  assign lock_view  = {lvl_mode[LOCK_CH], pol_sel[LOCK_CH]};

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (req_set == '0));

  p_edge_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_set & $past(req_set) & ~lvl_mode & ~$past(lvl_mode)
      & ~(pol_sel ^ $past(pol_sel))) == '0));

  p_level_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_active != '0) |=> ((req_set & $past(lvl_active)) == $past(lvl_active)));

  p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ksel == 2'b01) |=> !req_set[KEY_CH]);

  p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(LOCK_CH)) && !unlock) |=> $stable(lock_view));

endmodule

bind extint_conditioner extint_checker #(
  .NUM_CH  (NUM_CH),
  .KEY_CH  (KEY_CH),
  .LOCK_CH (LOCK_CH),
  .ADDR_W  (ADDR_W)
) u_extint_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .req_set  (req_set),
  .sig_s    (sig_s),
  .src_en   (src_en),
  .lvl_mode (lvl_mode),
  .pol_sel  (pol_sel),
  .key_ksel (key_ksel),
  .unlock   (unlock)
);

// File: tb/test_extint_conditioner.sv
`timescale 1ns/1ps
module test_extint_conditioner;

  logic       clk;
  logic       rst_n;
  logic [4:0] ext_pin;
  logic [4:0] key_in;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] req_set;

  extint_conditioner i_extint_conditioner (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_pin (ext_pin),
    .key_in  (key_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .req_set (req_set)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int ecount = 0;

  always @(posedge clk) ecount <= ecount + 1;

  typedef struct {
    int         due;
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  // bench-side view of the written configuration
  logic       sh_pol [5];
  logic       sh_lvl [5];
  logic [1:0] sh_ksel;
  logic       sh_unlock;
  logic [4:0] prv_p;
  logic [4:0] prv_k;

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: req_set=%b expected %b", tag, got, exp);
    end
  endtask

  // channel input as the requirements define it (R8, R9)
  function automatic logic ref_src(int ch, logic [4:0] p, logic [4:0] k);
    int  n;
    logic acc;
    if (ch != 3 || sh_ksel == 2'b00) return p[ch];
    n = (sh_ksel == 2'b11) ? 5 : 4;
    if (sh_pol[3]) begin
      acc = 1'b0;
      for (int i = 0; i < n; i++) if (k[i]) acc = 1'b1;
    end else begin
      acc = 1'b1;
      for (int i = 0; i < n; i++) if (!k[i]) acc = 1'b0;
    end
    return acc;
  endfunction

  // expected pulse from R2..R5, R10
  function automatic logic ref_req(int ch, logic cur, logic prv);
    if (ch == 3 && sh_ksel == 2'b01) return 1'b0;
    if (sh_lvl[ch]) return sh_pol[ch] ? !cur : cur;
    return sh_pol[ch] ? (cur && !prv) : (!cur && prv);
  endfunction

  // driver: apply inputs and push the expected result three edges later (R6)
  task automatic step(input logic [4:0] p, input logic [4:0] k, input string tag);
    logic [4:0] e;
    @(negedge clk);
    ext_pin = p;
    key_in  = k;
    for (int ch = 0; ch < 5; ch++)
      e[ch] = ref_req(ch, ref_src(ch, p, k), ref_src(ch, prv_p, prv_k));
    sbq.push_back('{ecount + 3, e, tag});
    prv_p = p;
    prv_k = k;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  // register write; bench models the lock of R11
  task automatic cfg(input logic [2:0] a, input logic [7:0] d);
    drain();
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd5) sh_unlock = d[5];
    else if (a < 3'd5 && (a != 3'd4 || sh_unlock)) begin
      sh_pol[a] = d[4];
      sh_lvl[a] = d[5];
      if (a == 3'd3) sh_ksel = d[7:6];
    end
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop and compare as results appear
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() != 0 && sbq[0].due == ecount) begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, req_set, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_pin = '0; key_in = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 5; i++) begin sh_pol[i] = 1'b0; sh_lvl[i] = 1'b0; end
    sh_ksel = 2'b00; sh_unlock = 1'b0; prv_p = '0; prv_k = '0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", req_set, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", req_set, 5'b00000);

    // R1: defaults are edge/pol0, so rising and high give nothing
    step(5'b11111, 5'b00000, "R1");
    step(5'b11111, 5'b00000, "R1");
    // R2: falling edges on every channel, one cycle each
    step(5'b00000, 5'b00000, "R2");
    step(5'b00000, 5'b00000, "R2");
    step(5'b10101, 5'b00000, "R2");
    step(5'b00100, 5'b00000, "R2 R12");
    step(5'b00100, 5'b00000, "R2");

    // R7: low bits ignored on ch0, pol bit 4 on ch1
    cfg(3'd0, 8'h0F);
    cfg(3'd1, 8'h10);
    step(5'b00011, 5'b00000, "R7");
    step(5'b00000, 5'b00000, "R7");
    step(5'b00000, 5'b00000, "R7");

    // R3 and R11: ch4 stays pol0 because it is locked
    cfg(3'd0, 8'h10);
    cfg(3'd2, 8'h10);
    cfg(3'd3, 8'h10);
    cfg(3'd4, 8'h10);
    step(5'b11111, 5'b00000, "R3");
    step(5'b11111, 5'b00000, "R3");
    step(5'b00000, 5'b00000, "R3 R11");
    step(5'b00000, 5'b00000, "R3");

    // R6: latency from a pin change to the pulse
    drain();
    @(negedge clk);
    ext_pin = 5'b00001;
    repeat (2) @(posedge clk);
    #2 chk("R6 after two edges", req_set, 5'b00000);
    @(posedge clk);
    #2 chk("R6 after third edge", req_set, 5'b00001);
    @(posedge clk);
    #2 chk("R6 after fourth edge", req_set, 5'b00000);
    prv_p = 5'b00001;

    // R11: unlock, then ch4 takes pol1; relock holds it
    cfg(3'd5, 8'h20);
    cfg(3'd4, 8'h10);
    step(5'b11111, 5'b00000, "R11");
    step(5'b00000, 5'b00000, "R11");
    cfg(3'd5, 8'h00);
    cfg(3'd4, 8'h20);
    step(5'b11111, 5'b00000, "R11 relocked");
    step(5'b11111, 5'b00000, "R11 relocked");

    // R4: level high repeats every cycle
    for (int a = 0; a < 4; a++) cfg(3'(a), 8'h20);
    step(5'b01111, 5'b00000, "R4");
    step(5'b01111, 5'b00000, "R4");
    step(5'b01111, 5'b00000, "R4");
    step(5'b00101, 5'b00000, "R4 R12");
    step(5'b00000, 5'b00000, "R4");

    // R5: level low repeats every cycle
    for (int a = 0; a < 4; a++) cfg(3'(a), 8'h30);
    step(5'b00000, 5'b00000, "R5");
    step(5'b00000, 5'b00000, "R5");
    step(5'b01010, 5'b00000, "R5");
    step(5'b01111, 5'b00000, "R5");

    // R8: narrow key group, AND then OR
    cfg(3'd3, 8'h80);
    step(5'b00000, 5'b01111, "R8");
    step(5'b01000, 5'b01111, "R8 pin ignored");
    step(5'b00000, 5'b11111, "R8 key4 ignored");
    step(5'b00000, 5'b01111, "R8 key4 ignored");
    step(5'b00000, 5'b01101, "R8 one key falls");
    step(5'b00000, 5'b01101, "R8");
    cfg(3'd3, 8'h90);
    step(5'b00000, 5'b00000, "R8");
    step(5'b00000, 5'b10000, "R8 key4 ignored");
    step(5'b00000, 5'b10100, "R8 one key rises");
    step(5'b00000, 5'b10100, "R8");

    // R9: wide key group
    cfg(3'd3, 8'hC0);
    step(5'b00000, 5'b11111, "R9");
    step(5'b00000, 5'b01111, "R9 key4 falls");
    step(5'b00000, 5'b11111, "R9");
    step(5'b00000, 5'b11110, "R9 key0 falls");
    cfg(3'd3, 8'hE0);
    step(5'b00000, 5'b11111, "R9 level");
    step(5'b00000, 5'b11111, "R9 level");
    step(5'b00000, 5'b11011, "R9 level");

    // R10: reserved source silences channel 3
    cfg(3'd3, 8'h60);
    step(5'b01000, 5'b11111, "R10");
    step(5'b00000, 5'b00000, "R10");
    step(5'b01000, 5'b11111, "R10");
    cfg(3'd3, 8'h50);
    step(5'b00000, 5'b00000, "R10");
    step(5'b01000, 5'b11111, "R10");

    drain();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule